// File: doc/BRIEF.md
# Peripheral Register Write-Protection Gate

This block stands between a peripheral's register bank and the bus that writes it, and decides for every write strobe whether the write may land. Each register location carries a fixed attribute. A location is either a debug mailbox, a guarded register, an open register, or unmapped. A lock input, driven by a separate access controller, blocks writes to guarded registers. Mailboxes and open registers are never subject to the lock. Unmapped locations take no writes at all.

The lock is overridden in two cases. The first is while the CPU is halted in debug mode. The second is when the write arrives from the external debug port rather than from the CPU. A write that is refused leaves the register unchanged and produces a one-cycle error pulse on the following cycle. Reads are combinational and never depend on the lock.

The block includes a small demonstration bank of eight 32-bit registers. Addresses 0 and 1 are the mailboxes. Addresses 2 to 5 are guarded. Addresses 6 and 7 are open read/write. Addresses 8 to 15 are unmapped.

Top module: `regguard_top`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), every address reads zero and wr_err is low.
- R2: A write to address 6 or 7 always updates the register at the clock edge of the strobe, whatever lock_in, and raises no error.
- R3: A write to mailbox address 0 or 1 always updates the register and raises no error, even with lock_in high and the CPU running.
- R4: A write to a guarded address (2 to 5) with lock_in low updates the register and raises no error.
- R5: A CPU write (wr_from_dbg low) to a guarded address with lock_in high and cpu_dbg_halt low leaves the register unchanged, and wr_err is high for exactly the one cycle after the strobe.
- R6: With cpu_dbg_halt high, a write to a guarded address succeeds even with lock_in high, with no error.
- R7: With wr_from_dbg high, a write to a guarded address succeeds even with lock_in high, with no error.
- R8: Addresses 8 to 15 always read zero, and writes to them are dropped without an error whatever the lock.
- R9: rd_data for any address is the same whether lock_in is high or low.
- R10: wr_err is high only in the cycle directly after a refused write strobe. Back-to-back strobes each get their own verdict.
- R11: lock_in is taken only in the cycle of the strobe, so a lock change in the next cycle does not alter that write's outcome.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wr_addr | input | 4 | Write register address |
| wr_data | input | 32 | Write data |
| wr_from_dbg | input | 1 | High when the write comes from the external debug port |
| cpu_dbg_halt | input | 1 | High while the CPU is halted in debug mode |
| lock_in | input | 1 | Write lock from the access controller |
| rd_addr | input | 4 | Read register address |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| wr_err | output | 1 | One-cycle pulse after a refused write |

## Verification
A refused write's error pulse and the outcome of the next strobe fall in the same cycle. The decision for a second write is made while the error of the first is on wr_err. The bench provokes this with strobes on consecutive cycles: a refused guarded write followed directly by an accepted open write, and two refused writes in a row. The scoreboard then expects wr_err high and then low in the first case, and high for two cycles in the second. The stored values of both targets are read back afterwards.

// File: rtl/regguard_pkg.sv
// Shared types and the attribute map for the write-protection gate.
// Assumes register indices count from zero. The mailboxes come first, then
// the guarded registers, then the open ones. Anything past NUM_REGS is unmapped.
package regguard_pkg;

    typedef enum logic [1:0] {
        RA_NONE    = 2'd0,
        RA_MAILBOX = 2'd1,
        RA_GUARDED = 2'd2,
        RA_OPEN    = 2'd3
    } reg_attr_e;

    // Attribute of one register index under the given layout.
    function automatic reg_attr_e attr_of(input int idx, input int mbox_n,
                                          input int guard_n, input int num_regs);
        if (idx >= num_regs)
            return RA_NONE;
        else if (idx < mbox_n)
            return RA_MAILBOX;
        else if (idx < mbox_n + guard_n)
            return RA_GUARDED;
        else
            return RA_OPEN;
    endfunction

endpackage

// File: rtl/rg_attr_decode.sv
// Maps a write address onto its register attribute.
// Assumes the layout parameters describe a bank no larger than the address space.
module rg_attr_decode #(
    parameter int ADDR_W     = 4,
    parameter int NUM_REGS   = 8,
    parameter int MBOX_REGS  = 2,
    parameter int GUARD_REGS = 4
) (
    input  logic [ADDR_W-1:0]      addr,
    output regguard_pkg::reg_attr_e attr
);
    import regguard_pkg::*;

    localparam int SPAN = 1 << ADDR_W;

    reg_attr_e attr_tab [SPAN];

    // Build the per-address attribute table at elaboration.
    for (genvar g = 0; g < SPAN; g++) begin : g_tab
        assign attr_tab[g] = attr_of(g, MBOX_REGS, GUARD_REGS, NUM_REGS);
    end

    // Select the attribute of the current address.
    always_comb begin
        attr = attr_tab[addr];
    end

endmodule

// File: rtl/rg_policy.sv
// Write policy: grants or refuses the strobe in its own cycle and registers
// a one-cycle error flag for each refusal.
// Assumes lock, halt and source are valid in the cycle of the strobe.
module rg_policy (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  regguard_pkg::reg_attr_e attr,
    input  logic                    lock,
    input  logic                    halted,
    input  logic                    from_dbg,
    output logic                    commit,
    output logic                    err_q
);
    import regguard_pkg::*;

    logic bypass;
    logic deny;

    // Decide whether this cycle's strobe lands or is refused.
    always_comb begin
        bypass = halted | from_dbg;
        commit = 1'b0;
        deny   = 1'b0;
        if (wr_en) begin
            unique case (attr)
                RA_MAILBOX: commit = 1'b1;
                RA_OPEN:    commit = 1'b1;
                RA_GUARDED: begin
                    commit = ~lock | bypass;
                    deny   = lock & ~bypass;
                end
                default:    commit = 1'b0;
            endcase
        end
    end

    // Turn a refusal into a pulse on the following cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else
            err_q <= deny;
    end

endmodule

// File: rtl/rg_bank.sv
// Demonstration register bank: NUM_REGS words loaded by a granted write,
// and a combinational read port that returns zero off the end.
// Assumes commit is only high for mapped, permitted addresses.
module rg_bank #(
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4,
    parameter int NUM_REGS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    logic [DATA_W-1:0] word_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        logic hit;
        assign hit = commit && (wr_addr == ADDR_W'(g));

        // Hold or load one register word.
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q[g] <= '0;
            else if (hit)
                word_q[g] <= wr_data;
        end
    end

    // Return the addressed word, or zero for an unmapped address.
    always_comb begin
        if (int'(rd_addr) < NUM_REGS)
            rd_data = word_q[rd_addr[IDX_W-1:0]];
        else
            rd_data = '0;
    end

endmodule

// File: rtl/regguard_top.sv
// Top of the write-protection gate: decodes the attribute of the target,
// applies the lock with its debug overrides and writes the demonstration bank.
// Assumes one write per strobe cycle and a synchronous active-low reset.
module regguard_top #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int NUM_REGS   = 8,
    parameter int MBOX_REGS  = 2,
    parameter int GUARD_REGS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_from_dbg,
    input  logic              cpu_dbg_halt,
    input  logic              lock_in,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              wr_err
);
    import regguard_pkg::*;

    reg_attr_e wr_attr;
    logic      commit;

    rg_attr_decode #(
        .ADDR_W    (ADDR_W),
        .NUM_REGS  (NUM_REGS),
        .MBOX_REGS (MBOX_REGS),
        .GUARD_REGS(GUARD_REGS)
    ) dec_i (
        .addr(wr_addr),
        .attr(wr_attr)
    );

    rg_policy pol_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .attr    (wr_attr),
        .lock    (lock_in),
        .halted  (cpu_dbg_halt),
        .from_dbg(wr_from_dbg),
        .commit  (commit),
        .err_q   (wr_err)
    );

    rg_bank #(
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .NUM_REGS(NUM_REGS)
    ) bank_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .commit (commit),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

endmodule

// File: rtl/rg_guard_chk.sv
// Property checker for the write-protection gate, bound onto regguard_top.
// Sees only the top-level ports and relates them across cycles.
module rg_guard_chk #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int NUM_REGS   = 8,
    parameter int MBOX_REGS  = 2,
    parameter int GUARD_REGS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_from_dbg,
    input logic              cpu_dbg_halt,
    input logic              lock_in,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic              wr_err
);
    logic tgt_guarded, tgt_mbox, refused, overridden;

    // Classify the write target and the expected verdict.
    always_comb begin
        tgt_mbox    = int'(wr_addr) < MBOX_REGS;
        tgt_guarded = (int'(wr_addr) >= MBOX_REGS) && (int'(wr_addr) < MBOX_REGS + GUARD_REGS);
        overridden  = cpu_dbg_halt | wr_from_dbg;
        refused     = wr_en && tgt_guarded && lock_in && !overridden;
    end

    // R5
    refused_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        refused |=> wr_err);

    // R5
    refused_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (refused && rd_addr == wr_addr) |=> (!$stable(rd_addr) || $stable(rd_data)));

    // R10
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !refused) |=> !wr_err);

    // R3
    mailbox_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tgt_mbox) |=> !wr_err);

    // R6 R7
    override_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tgt_guarded && overridden && rd_addr == wr_addr)
        |=> (!$stable(rd_addr) || rd_data == $past(wr_data)));

    // R8
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(rd_addr) >= NUM_REGS) |-> (rd_data == '0));

endmodule

bind regguard_top rg_guard_chk #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .NUM_REGS  (NUM_REGS),
    .MBOX_REGS (MBOX_REGS),
    .GUARD_REGS(GUARD_REGS)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_from_dbg (wr_from_dbg),
    .cpu_dbg_halt(cpu_dbg_halt),
    .lock_in     (lock_in),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .wr_err      (wr_err)
);

// File: tb/regguard_top_tb_top.sv
// Scoreboard bench for regguard_top: the driver queues the expected error
// verdict of each strobe, and the monitor checks it one edge later.
module regguard_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        wr_from_dbg = 1'b0;
    logic        cpu_dbg_halt = 1'b0;
    logic        lock_in = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        wr_err;

    typedef struct {
        logic  err;
        string tag;
    } sb_item_t;

    sb_item_t    sb_q[$];
    logic [31:0] model [16];
    int          n_chk = 0;
    int          n_err = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    regguard_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_from_dbg(wr_from_dbg), .cpu_dbg_halt(cpu_dbg_halt),
        .lock_in(lock_in), .rd_addr(rd_addr), .rd_data(rd_data), .wr_err(wr_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one strobe, with the expected verdict taken from the requirements.
    task automatic wr(input logic [3:0] a, input logic [31:0] d, input logic lk,
                      input logic hl, input logic dg, input string tag);
        logic blk;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        lock_in = lk; cpu_dbg_halt = hl; wr_from_dbg = dg;
        blk = (a >= 4'd2) && (a <= 4'd5) && lk && !hl && !dg;
        if (a < 4'd8 && !blk) model[a] = d;
        sb_q.push_back('{err: blk, tag: tag});
    endtask

    task automatic idle(input logic lk_after);
        @(negedge clk);
        wr_en = 1'b0; lock_in = lk_after; cpu_dbg_halt = 1'b0; wr_from_dbg = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input string tag);
        @(negedge clk);
        rd_addr = a;
        #1;
        check(tag, rd_data, model[a]);
    endtask

    // Monitor: compare wr_err one time unit after each edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                if (sb_q.size() > 0) begin
                    sb_item_t it;
                    it = sb_q.pop_front();
                    check({it.tag, " wr_err"}, 32'(wr_err), 32'(it.err));
                end else begin
                    check("R10 idle wr_err", 32'(wr_err), 32'd0);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #400000;
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: everything zero after reset
        for (int i = 0; i < 16; i++) rd_chk(4'(i), "R1 reset read");
        check("R1 reset wr_err", 32'(wr_err), 32'd0);

        // R2: open registers ignore the lock
        wr(4'd6, 32'hA5A5_0006, 1'b1, 1'b0, 1'b0, "R2");
        wr(4'd7, 32'h1234_0007, 1'b0, 1'b0, 1'b0, "R2");
        idle(1'b0);
        rd_chk(4'd6, "R2 open reg 6");
        rd_chk(4'd7, "R2 open reg 7");

        // R3: mailboxes always writable
        wr(4'd0, 32'hDEAD_0000, 1'b1, 1'b0, 1'b0, "R3");
        wr(4'd1, 32'hBEEF_0001, 1'b1, 1'b0, 1'b0, "R3");
        idle(1'b1);
        rd_chk(4'd0, "R3 mailbox 0");
        rd_chk(4'd1, "R3 mailbox 1");

        // R4: guarded registers unlocked
        for (int i = 2; i <= 5; i++) wr(4'(i), 32'h5000_0000 + 32'(i), 1'b0, 1'b0, 1'b0, "R4");
        idle(1'b0);
        for (int i = 2; i <= 5; i++) rd_chk(4'(i), "R4 guarded unlocked");

        // R5 R10: refused write then accepted write on the next cycle
        wr(4'd3, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, "R5 refused");
        wr(4'd6, 32'h0606_0606, 1'b1, 1'b0, 1'b0, "R10 next strobe");
        idle(1'b0);
        rd_chk(4'd3, "R5 refused unchanged");
        rd_chk(4'd6, "R10 next strobe landed");

        // R10: two refused strobes back to back
        wr(4'd2, 32'h1111_1111, 1'b1, 1'b0, 1'b0, "R10 refused a");
        wr(4'd5, 32'h2222_2222, 1'b1, 1'b0, 1'b0, "R10 refused b");
        idle(1'b1);
        rd_chk(4'd2, "R10 refused a unchanged");
        rd_chk(4'd5, "R10 refused b unchanged");

        // R6: debug halt overrides lock
        wr(4'd4, 32'h4444_6666, 1'b1, 1'b1, 1'b0, "R6");
        idle(1'b1);
        rd_chk(4'd4, "R6 halt write");

        // R7: debug-port source overrides lock
        wr(4'd5, 32'h5555_7777, 1'b1, 1'b0, 1'b1, "R7");
        idle(1'b1);
        rd_chk(4'd5, "R7 debug-port write");

        // R8: unmapped addresses
        wr(4'd9, 32'hCAFE_0009, 1'b0, 1'b0, 1'b0, "R8");
        wr(4'd15, 32'hCAFE_000F, 1'b1, 1'b0, 1'b0, "R8");
        idle(1'b1);
        rd_chk(4'd9, "R8 unmapped 9");
        rd_chk(4'd15, "R8 unmapped 15");

        // R9: reads under lock high and low
        lock_in = 1'b1;
        for (int i = 0; i < 8; i++) rd_chk(4'(i), "R9 read locked");
        lock_in = 1'b0;
        for (int i = 0; i < 8; i++) rd_chk(4'(i), "R9 read unlocked");

        // R11: lock changing after the strobe does not matter
        wr(4'd2, 32'h0B11_0002, 1'b0, 1'b0, 1'b0, "R11 unlocked then lock");
        idle(1'b1);
        wr(4'd3, 32'h0B11_0003, 1'b1, 1'b0, 1'b0, "R11 locked then unlock");
        idle(1'b0);
        rd_chk(4'd2, "R11 write landed");
        rd_chk(4'd3, "R11 write refused");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule